// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, every cycle, whether the decode stage of a simple in-order integer pipeline must stall and whether the whole pipeline must be frozen. It takes the descriptor of the instruction now in decode. That descriptor says whether the instruction writes the condition codes, whether it is a load, its destination register, two source registers with use flags, whether it is a conditional branch or trap, and its static prediction. The block also takes a busy flag from the store buffer.

The block keeps its own record of the two older stages, execute and memory. The record advances as instructions leave decode, takes a bubble on a stall, and stays frozen on a hold. From that record it raises two kinds of stall. A condition-code interlock applies when a branch or trap follows an instruction that writes the codes. A load-use stall applies when an instruction reads the result of the load just ahead of it. A busy store buffer drives the global hold. The hold never absorbs a stall: a stall that is pending still costs its full penalty once the hold ends.

Top module: `hz_stall_ctrl`

## Requirements
- R1: After reset both older stages are empty, so `stall_o` and `hold_o` are 0 with `sb_busy_i` low, even when a branch sits in decode.
- R2: A conditional branch or trap in decode directly behind an instruction that writes the condition codes (distance 1) stalls for exactly 2 cycles.
- R3: At distance 2 from the writer of the condition codes, a conditional branch or trap stalls for exactly 1 cycle.
- R4: At distance 3 or more, or when no older instruction writes the codes or loads, there is no stall.
- R5: With the parameter `PREDICT_EN`=1, a branch marked predicted-taken (`dec_pred_taken_i`=1) pays no condition-code stall at any distance.
- R6: An instruction whose enabled source register equals the destination of a load in the execute stage stalls for exactly 1 cycle. The stall sends a bubble to execute. A load at distance 2 causes no stall.
- R7: Register 0 never creates a load-use dependency. A source field whose use flag is 0 is ignored.
- R8: `hold_o` is high in exactly the cycles in which `sb_busy_i` is high. While it is high, neither older stage changes and decode does not advance.
- R9: Hold cycles never absorb a pending stall. The number of stall cycles outside the hold equals the penalty without a hold. The total time in decode equals that penalty plus the hold length plus 1.
- R10: When a condition-code interlock and a load-use stall apply together, the stall lasts as long as the longer of the two, not their sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_wcc_i | input | 1 | Decode instruction writes condition codes |
| dec_load_i | input | 1 | Decode instruction is a load |
| dec_bcc_i | input | 1 | Decode instruction is a conditional branch or trap |
| dec_pred_taken_i | input | 1 | Static prediction says taken |
| dec_rd_i | input | REG_W | Destination register |
| dec_rs1_i | input | REG_W | First source register |
| dec_rs1_use_i | input | 1 | First source is read |
| dec_rs2_i | input | REG_W | Second source register |
| dec_rs2_use_i | input | 1 | Second source is read |
| sb_busy_i | input | 1 | Store buffer blocking |
| stall_o | output | 1 | Decode stall, bubble into execute |
| hold_o | output | 1 | Whole-pipeline hold |

## Verification
A store-buffer hold and a pending interlock or load-use stall can fall in the same cycle. The bench provokes this by raising the busy flag while a dependent branch or consumer waits in decode. It also raises the flag while the producer or a filler instruction is in decode, so the older stages are frozen mid-sequence. Each case is judged by counting the cycles that stall without a hold, which must equal the penalty set by distance, prediction and register match. The total time in decode must equal that penalty plus the hold length plus one.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int REG_W = 5;
  localparam int NSRC  = 2;

  typedef logic [REG_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     valid;
    logic     wcc;
    logic     load;
    reg_idx_t rd;
  } stage_desc_t;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hold_i,
  input  logic        stall_i,
  input  stage_desc_t dec_i,
  output stage_desc_t ex_o,
  output stage_desc_t mem_o
);
  stage_desc_t ex_q, mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_q  <= '0;
      mem_q <= '0;
    end else if (!hold_i) begin
      mem_q <= ex_q;
      // stall: decode keeps its instruction, execute gets a bubble
      ex_q  <= (stall_i || !dec_i.valid) ? '0 : dec_i;
    end
  end

  assign ex_o  = ex_q;
  assign mem_o = mem_q;
endmodule

// File: rtl/hz_cc_interlock.sv
module hz_cc_interlock #(
  parameter bit PREDICT_EN = 1'b1
) (
  input  logic bcc_i,
  input  logic pred_taken_i,
  input  logic ex_wcc_i,
  input  logic mem_wcc_i,
  output logic stall_o
);
  logic hidden;

  generate
    if (PREDICT_EN) begin : g_pred
      assign hidden = pred_taken_i;
    end else begin : g_nopred
      logic unused_pred;
      assign unused_pred = pred_taken_i;
      assign hidden = 1'b0;
    end
  endgenerate

  assign stall_o = bcc_i && !hidden && (ex_wcc_i || mem_wcc_i);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
(
  input  logic                ex_valid_i,
  input  logic                ex_load_i,
  input  reg_idx_t            ex_rd_i,
  input  reg_idx_t [NSRC-1:0] src_i,
  input  logic     [NSRC-1:0] use_i,
  output logic                stall_o
);
  logic [NSRC-1:0] hit;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = use_i[i] && (src_i[i] == ex_rd_i);
    end
  endgenerate

  // r0 is hardwired, never a dependency
  assign stall_o = ex_valid_i && ex_load_i && (ex_rd_i != '0) && (|hit);
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter bit PREDICT_EN = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dec_valid_i,
  input  logic                  dec_wcc_i,
  input  logic                  dec_load_i,
  input  logic                  dec_bcc_i,
  input  logic                  dec_pred_taken_i,
  input  logic [hz_pkg::REG_W-1:0] dec_rd_i,
  input  logic [hz_pkg::REG_W-1:0] dec_rs1_i,
  input  logic                  dec_rs1_use_i,
  input  logic [hz_pkg::REG_W-1:0] dec_rs2_i,
  input  logic                  dec_rs2_use_i,
  input  logic                  sb_busy_i,
  output logic                  stall_o,
  output logic                  hold_o
);
  stage_desc_t dec_d, ex_q, mem_q;
  logic cc_stall, lu_stall, stall;
  reg_idx_t [NSRC-1:0] srcs;
  logic     [NSRC-1:0] uses;

  assign dec_d = '{valid: dec_valid_i, wcc: dec_wcc_i, load: dec_load_i, rd: dec_rd_i};
  assign srcs  = {dec_rs2_i, dec_rs1_i};
  assign uses  = {dec_rs2_use_i, dec_rs1_use_i};

  hz_stage_track u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (sb_busy_i),
    .stall_i (stall),
    .dec_i   (dec_d),
    .ex_o    (ex_q),
    .mem_o   (mem_q)
  );

  hz_cc_interlock #(.PREDICT_EN(PREDICT_EN)) u_cc (
    .bcc_i        (dec_bcc_i),
    .pred_taken_i (dec_pred_taken_i),
    .ex_wcc_i     (ex_q.valid && ex_q.wcc),
    .mem_wcc_i    (mem_q.valid && mem_q.wcc),
    .stall_o      (cc_stall)
  );

  hz_load_use u_lu (
    .ex_valid_i (ex_q.valid),
    .ex_load_i  (ex_q.load),
    .ex_rd_i    (ex_q.rd),
    .src_i      (srcs),
    .use_i      (uses),
    .stall_o    (lu_stall)
  );

  assign stall   = dec_valid_i && (cc_stall || lu_stall);
  assign stall_o = stall;
  assign hold_o  = sb_busy_i;
endmodule

// File: rtl/hz_stall_ctrl_chk.sv
module hz_stall_ctrl_chk
  import hz_pkg::*;
#(
  parameter bit PREDICT_EN = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dec_valid_i,
  input logic        dec_bcc_i,
  input logic        dec_pred_taken_i,
  input logic        stall_o,
  input logic        hold_o,
  input stage_desc_t ex_q,
  input stage_desc_t mem_q
);
  // R8
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> ($stable(ex_q) && $stable(mem_q)));

  // R6
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !hold_o) |=> !ex_q.valid);

  // R7
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_q.load && ex_q.rd == '0 && !(dec_bcc_i && (ex_q.wcc || mem_q.wcc))) |-> !stall_o);

  // R4
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_q.wcc && !mem_q.wcc && !ex_q.load) |-> !stall_o);

  // R2
  cc_near_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_bcc_i && !(PREDICT_EN && dec_pred_taken_i) && ex_q.valid && ex_q.wcc)
      |-> stall_o);

  generate
    if (PREDICT_EN) begin : g_pred
      // R5
      pred_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_bcc_i && dec_pred_taken_i && !ex_q.load) |-> !stall_o);
    end
  endgenerate
endmodule

bind hz_stall_ctrl hz_stall_ctrl_chk #(.PREDICT_EN(PREDICT_EN)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .dec_valid_i      (dec_valid_i),
  .dec_bcc_i        (dec_bcc_i),
  .dec_pred_taken_i (dec_pred_taken_i),
  .stall_o          (stall_o),
  .hold_o           (hold_o),
  .ex_q             (ex_q),
  .mem_q            (mem_q)
);

// File: tb/sim_hz_stall_ctrl.sv
module sim_hz_stall_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, dec_wcc = 1'b0, dec_load = 1'b0, dec_bcc = 1'b0, dec_pred = 1'b0;
  logic [4:0] dec_rd = '0, dec_rs1 = '0, dec_rs2 = '0;
  logic dec_u1 = 1'b0, dec_u2 = 1'b0, sb_busy = 1'b0;
  logic stall, hold;
  int checks = 0, errors = 0, hold_mis = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hz_stall_ctrl #(.PREDICT_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_wcc_i(dec_wcc),
    .dec_load_i(dec_load), .dec_bcc_i(dec_bcc), .dec_pred_taken_i(dec_pred),
    .dec_rd_i(dec_rd), .dec_rs1_i(dec_rs1), .dec_rs1_use_i(dec_u1),
    .dec_rs2_i(dec_rs2), .dec_rs2_use_i(dec_u2), .sb_busy_i(sb_busy),
    .stall_o(stall), .hold_o(hold)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called just after a negedge; returns after the instruction leaves decode
  task automatic issue(input logic bcc, input logic pred, input logic wcc, input logic ld,
                       input logic [4:0] rd, input logic [4:0] rs1, input logic u1,
                       input logic [4:0] rs2, input logic u2,
                       input int hat, input int hlen, output int n_stall, output int n_cyc);
    logic s, h;
    n_stall = 0;
    n_cyc = 0;
    dec_valid = 1'b1; dec_bcc = bcc; dec_pred = pred; dec_wcc = wcc; dec_load = ld;
    dec_rd = rd; dec_rs1 = rs1; dec_u1 = u1; dec_rs2 = rs2; dec_u2 = u2;
    forever begin
      sb_busy = (hlen > 0) && (n_cyc >= hat) && (n_cyc < hat + hlen);
      #1;
      s = stall;
      h = hold;
      if (h !== sb_busy) hold_mis++;
      n_cyc++;
      if (s && !h) n_stall++;
      @(negedge clk);
      if (!s && !h) break;
      if (n_cyc > 60) break;
    end
    sb_busy = 1'b0;
  endtask

  task automatic nop2();
    int a, b;
    for (int i = 0; i < 2; i++) issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, a, b);
  endtask

  // kind 0: condition-code producer then branch; kind 1: load then consumer
  task automatic run_case(input int kind, input int d, input logic pred, input logic [4:0] r,
                          input int var_, input int hold_on, input int hat, input int hlen,
                          input string req);
    int ns, nc, exp;
    logic m1, m2;
    logic [4:0] rs1, rs2;
    m1 = 0; m2 = 0; rs1 = 5'd9; rs2 = 5'd10;
    case (var_)
      0: begin rs1 = r; m1 = 1; end
      1: begin rs2 = r; m2 = 1; end
      2: begin rs1 = r; end
      default: ;
    endcase
    if (kind == 0) begin
      exp = (pred) ? 0 : ((d < 3) ? 3 - d : 0);
      issue(0, 0, 1, 0, 5'd4, 0, 0, 0, 0, (hold_on == 0) ? hat : 0, (hold_on == 0) ? hlen : 0, ns, nc);
    end else begin
      exp = (d == 1 && r != 0 && (m1 || m2)) ? 1 : 0;
      issue(0, 0, 0, 1, r, 0, 0, 0, 0, (hold_on == 0) ? hat : 0, (hold_on == 0) ? hlen : 0, ns, nc);
    end
    check({req, " producer stall"}, ns, 0);
    for (int f = 1; f < d; f++)
      issue(0, 0, 0, 0, 5'd7, 0, 0, 0, 0, (hold_on == 1 && f == 1) ? hat : 0,
            (hold_on == 1 && f == 1) ? hlen : 0, ns, nc);
    if (kind == 0)
      issue(1, pred, 0, 0, 0, 5'd4, 1, 0, 0, (hold_on == 2) ? hat : 0, (hold_on == 2) ? hlen : 0, ns, nc);
    else
      issue(0, 0, 0, 0, 5'd11, rs1, m1, rs2, m2, (hold_on == 2) ? hat : 0, (hold_on == 2) ? hlen : 0, ns, nc);
    check({req, " stall cycles"}, ns, exp);
    check({req, " R9 decode cycles"}, nc,
          exp + 1 + ((hold_on == 2 && hlen > 0 && hat <= exp) ? hlen : 0));
    nop2();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d CHECKS_END", 0);
    end
  end

  initial begin
    int ns, nc;
    string tag;
    dec_valid = 1'b1; dec_bcc = 1'b1; dec_rs1 = 5'd4; dec_u1 = 1'b1;
    #5;
    // R1
    check("R1 stall in reset", int'(stall), 0);
    check("R1 hold in reset", int'(hold), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 branch right after reset sees empty older stages
    check("R1 stall after reset", int'(stall), 0);
    @(negedge clk);
    nop2();

    for (int d = 1; d <= 3; d++)
      for (int p = 0; p < 2; p++)
        for (int ho = 0; ho < 4; ho++)
          for (int hp = 0; hp < 2; hp++) begin
            tag = (p == 1) ? "R5" : (d == 1) ? "R2" : (d == 2) ? "R3" : "R4";
            if (ho == 2) tag = {tag, "/R9"};
            if (ho == 0 || ho == 1) tag = {tag, "/R8"};
            run_case(0, d, p[0], 5'd0, 0, ho, hp, 2 + hp, tag);
          end

    for (int d = 1; d <= 2; d++)
      for (int ri = 0; ri < 3; ri++)
        for (int v = 0; v < 4; v++)
          for (int ho = 2; ho < 4; ho++) begin
            logic [4:0] r;
            r = (ri == 0) ? 5'd0 : (ri == 1) ? 5'd1 : 5'd5;
            tag = (ri == 0 || v >= 2) ? "R7" : (d == 1) ? "R6" : "R4";
            run_case(1, d, 1'b0, r, v, ho, 0, (ho == 2) ? 3 : 0, tag);
          end

    // R10: cc writer at distance 2 plus load at distance 1 -> 1 cycle
    issue(0, 0, 1, 0, 5'd4, 0, 0, 0, 0, 0, 0, ns, nc);
    issue(0, 0, 0, 1, 5'd3, 0, 0, 0, 0, 0, 0, ns, nc);
    issue(1, 0, 0, 0, 0, 5'd3, 1, 0, 0, 0, 0, ns, nc);
    check("R10 overlap d2+load", ns, 1);
    nop2();
    // R10: load that also writes codes at distance 1 -> 2 cycles, with hold
    issue(0, 0, 1, 1, 5'd3, 0, 0, 0, 0, 0, 0, ns, nc);
    issue(1, 0, 0, 0, 0, 5'd3, 1, 0, 0, 1, 2, ns, nc);
    check("R10 overlap d1+load", ns, 2);
    check("R10 R9 overlap decode cycles", nc, 5);
    nop2();

    // R8
    check("R8 hold mirrors busy", hold_mis, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule